// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits between a host's strobe-style bus and a small flash array model. It watches every write and tracks the multi-write unlock sequences that a host uses to reach the identifier page or to start a whole-chip erase. Each write is taken on the rising edge of the active-low write strobe. The strobe is sampled in the block's clock domain, and address and data must be stable around that edge.

Reads are combinational from the current mode. In the normal mode they return the array data. In identifier mode they return a manufacturer code, a device code or the protection flag, picked by the two lowest address bits. While the erase sequencer reports busy, they return that sequencer's status byte. A width select chooses word (16-bit) or byte (8-bit) results. In byte mode the upper byte is driven to zero.

When a full erase sequence is accepted, the block pulses a start line to the erase sequencer. A reset command pulses an abort line when an operation is running or has failed.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and after any write with data F0h, the block is in array mode. In that mode rdata equals array_rdata in word mode (word_mode=1), and equals {8'h00, array_rdata[7:0]} in byte mode (word_mode=0).
- R2: A write of F0h while busy=1 or op_fail=1 produces exactly one erase_abort pulse of one cycle. An F0h write with both low produces none.
- R3: The write sequence AAh@555h, 55h@2AAh, 90h@555h enters identifier mode. There, a read with addr[1:0]=00 returns MFR_CODE, zero-extended to 16 bits. The block stays in identifier mode across any number of reads.
- R4: In identifier mode, a read with addr[1:0]=01 returns {DEV_HI, DEV_CODE} in word mode and {8'h00, DEV_CODE} in byte mode.
- R5: In identifier mode, a read with addr[1:0]=10 returns 16'h0001 when sector_prot=1 and 16'h0000 when it is 0. A read with addr[1:0]=11 returns 16'h0000.
- R6: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h produce exactly one erase_start pulse, one cycle wide, and leave the block in array mode.
- R7: erase_start is high in the clock cycle right after the first clock edge at which we_n is sampled high following the final write of the sequence.
- R8: A write whose address or data does not match the expected step returns the block to array mode. Such a write produces no erase_start, including a mismatch at any of the six erase steps, and it leaves identifier mode.
- R9: While busy=1, rdata equals {8'h00, status} whatever the mode and address.
- R10: While busy=1, every write other than F0h is ignored: it advances no sequence, changes no mode and produces no erase_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we_n | input | 1 | Active-low write strobe; a write is taken on its rising edge |
| addr | input | ADDR_W | Bus address for writes and reads |
| wdata | input | 8 | Command data of a write |
| word_mode | input | 1 | 1 selects 16-bit reads, 0 selects byte reads |
| array_rdata | input | 16 | Data from the array model |
| sector_prot | input | 1 | Protection flag of the addressed sector |
| busy | input | 1 | Erase sequencer running |
| op_fail | input | 1 | Erase sequencer reports a failed operation |
| status | input | 8 | Status byte of the erase sequencer |
| rdata | output | 16 | Read data to the host |
| erase_start | output | 1 | One-cycle erase start pulse |
| erase_abort | output | 1 | One-cycle abort pulse to the erase sequencer |

## Verification
The identifier page is swept over all four low-address values, both widths and both protection states. This separates each code source and shows the byte-mode zeroing. For every one of the six erase steps, the bench corrupts first the address and then the data, which shows that no partial history leads to a start and that each step checks both fields. The full sequence is then run again with the start sampled cycle by cycle to pin its timing. Busy windows are mixed with identifier and erase sequences and with F0h writes under each combination of busy and failure. These runs tell ignored writes apart from abort commands and status reads apart from array reads.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_UNL1   = 3'd1,
        ST_UNL2   = 3'd2,
        ST_SETUP  = 3'd3,
        ST_SUNL1  = 3'd4,
        ST_SUNL2  = 3'd5
    } seq_step_e;

    typedef struct packed {
        seq_step_e step;
        logic      id_mode;
        logic      we_q;
        logic      start;
        logic      abort;
    } seq_state_t;

    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_IDENT    = 8'h90;
    localparam logic [7:0] CMD_SETUP    = 8'h80;
    localparam logic [7:0] CMD_CONFIRM  = 8'h10;
    localparam logic [7:0] CMD_RESET    = 8'hF0;

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] ADDR_A = 'h555,
    parameter logic [ADDR_W-1:0] ADDR_B = 'h2AA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    input  logic              op_fail,
    output logic              id_mode,
    output logic              erase_start,
    output logic              erase_abort
);

    seq_state_t st_d, st_q;

    logic wr_edge;
    logic at_a, at_b;

    always_comb begin
        wr_edge = st_q.we_q == 1'b0 && we_n == 1'b1;
        at_a    = addr == ADDR_A;
        at_b    = addr == ADDR_B;

        st_d       = st_q;
        st_d.we_q  = we_n;
        st_d.start = 1'b0;
        st_d.abort = 1'b0;

        if (wr_edge) begin
            if (wdata == CMD_RESET) begin
                st_d.step    = ST_IDLE;
                st_d.id_mode = 1'b0;
                st_d.abort   = busy | op_fail;
            end else if (!busy) begin
                st_d.step = ST_IDLE;
                unique case (st_q.step)
                    ST_IDLE: begin
                        if (at_a && wdata == CMD_UNLOCK_A) st_d.step = ST_UNL1;
                        else                                st_d.id_mode = 1'b0;
                    end
                    ST_UNL1: begin
                        if (at_b && wdata == CMD_UNLOCK_B) st_d.step = ST_UNL2;
                        else                                st_d.id_mode = 1'b0;
                    end
                    ST_UNL2: begin
                        if (at_a && wdata == CMD_IDENT) begin
                            st_d.id_mode = 1'b1;
                        end else if (at_a && wdata == CMD_SETUP) begin
                            st_d.step    = ST_SETUP;
                            st_d.id_mode = 1'b0;
                        end else begin
                            st_d.id_mode = 1'b0;
                        end
                    end
                    ST_SETUP: begin
                        if (at_a && wdata == CMD_UNLOCK_A) st_d.step = ST_SUNL1;
                    end
                    ST_SUNL1: begin
                        if (at_b && wdata == CMD_UNLOCK_B) st_d.step = ST_SUNL2;
                    end
                    ST_SUNL2: begin
                        if (at_a && wdata == CMD_CONFIRM) st_d.start = 1'b1;
                    end
                    default: st_d.id_mode = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.step    <= ST_IDLE;
            st_q.id_mode <= 1'b0;
            st_q.we_q    <= 1'b1;
            st_q.start   <= 1'b0;
            st_q.abort   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign id_mode     = st_q.id_mode;
    assign erase_start = st_q.start;
    assign erase_abort = st_q.abort;

endmodule

// File: rtl/flash_id_sel.sv
module flash_id_sel #(
    parameter logic [7:0] MFR_CODE = 8'hC2,
    parameter logic [7:0] DEV_CODE = 8'h51,
    parameter logic [7:0] DEV_HI   = 8'h22
) (
    input  logic [1:0]  sel,
    input  logic        word_mode,
    input  logic        sector_prot,
    output logic [15:0] id_data
);

    logic [7:0] lo_byte;
    logic [7:0] hi_byte;

    always_comb begin
        lo_byte = 8'h00;
        hi_byte = 8'h00;
        unique case (sel)
            2'b00: lo_byte = MFR_CODE;
            2'b01: begin
                lo_byte = DEV_CODE;
                hi_byte = DEV_HI;
            end
            2'b10: lo_byte = {7'd0, sector_prot};
            default: lo_byte = 8'h00;
        endcase
        id_data = {word_mode ? hi_byte : 8'h00, lo_byte};
    end

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux #(
    parameter int DATA_W = 16,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              busy,
    input  logic              id_mode,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic [DATA_W-1:0] id_data,
    input  logic [HALF_W-1:0] status,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        if (busy) begin
            rdata = {{HALF_W{1'b0}}, status};
        end else if (id_mode) begin
            rdata = id_data;
        end else if (word_mode) begin
            rdata = array_rdata;
        end else begin
            rdata = {{HALF_W{1'b0}}, array_rdata[HALF_W-1:0]};
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W = 12,
    parameter logic [7:0] MFR_CODE = 8'hC2,
    parameter logic [7:0] DEV_CODE = 8'h51,
    parameter logic [7:0] DEV_HI   = 8'h22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              word_mode,
    input  logic [15:0]       array_rdata,
    input  logic              sector_prot,
    input  logic              busy,
    input  logic              op_fail,
    input  logic [7:0]        status,
    output logic [15:0]       rdata,
    output logic              erase_start,
    output logic              erase_abort
);

    logic        id_mode;
    logic [15:0] id_data;

    flash_seq_fsm #(
        .ADDR_W (ADDR_W)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_n        (we_n),
        .addr        (addr),
        .wdata       (wdata),
        .busy        (busy),
        .op_fail     (op_fail),
        .id_mode     (id_mode),
        .erase_start (erase_start),
        .erase_abort (erase_abort)
    );

    flash_id_sel #(
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE),
        .DEV_HI   (DEV_HI)
    ) i_id (
        .sel         (addr[1:0]),
        .word_mode   (word_mode),
        .sector_prot (sector_prot),
        .id_data     (id_data)
    );

    flash_read_mux #(
        .DATA_W (16)
    ) i_rmux (
        .busy        (busy),
        .id_mode     (id_mode),
        .word_mode   (word_mode),
        .array_rdata (array_rdata),
        .id_data     (id_data),
        .status      (status),
        .rdata       (rdata)
    );

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        we_n,
    input logic [7:0]  wdata,
    input logic        busy,
    input logic [7:0]  status,
    input logic [15:0] rdata,
    input logic        erase_start,
    input logic        erase_abort
);

    // R6: the start line is a single-cycle pulse
    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    // R7: start follows a low-to-high strobe transition seen at the previous two edges
    p_start_after_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> ($past(we_n) && !$past(we_n, 2)));

    // R10: no start is accepted from a write made while busy
    p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> !$past(busy));

    // R2: abort only after a reset command write
    p_abort_on_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        erase_abort |-> ($past(we_n) && $past(wdata) == 8'hF0));

    // R2: abort is a single-cycle pulse
    p_abort_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        erase_abort |=> !erase_abort);

    // R9: busy reads deliver the status byte
    p_busy_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rdata == {8'h00, status});

endmodule

bind flash_cmd_decoder flash_cmd_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_n        (we_n),
    .wdata       (wdata),
    .busy        (busy),
    .status      (status),
    .rdata       (rdata),
    .erase_start (erase_start),
    .erase_abort (erase_abort)
);

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        word_mode = 1'b1;
    logic [15:0] array_rdata = 16'hA53C;
    logic        sector_prot = 1'b0;
    logic        busy = 1'b0;
    logic        op_fail = 1'b0;
    logic [7:0]  status = 8'h00;
    logic [15:0] rdata;
    logic        erase_start;
    logic        erase_abort;

    int checks = 0;
    int errors = 0;
    int start_cnt = 0;
    int abort_cnt = 0;
    bit done = 1'b0;

    localparam logic [7:0] MFR = 8'hC2;
    localparam logic [7:0] DEV = 8'h51;
    localparam logic [7:0] DHI = 8'h22;

    always #5 clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk (clk), .rst_n (rst_n), .we_n (we_n), .addr (addr), .wdata (wdata),
        .word_mode (word_mode), .array_rdata (array_rdata), .sector_prot (sector_prot),
        .busy (busy), .op_fail (op_fail), .status (status), .rdata (rdata),
        .erase_start (erase_start), .erase_abort (erase_abort)
    );

    always @(negedge clk) begin
        if (erase_start) start_cnt++;
        if (erase_abort) abort_cnt++;
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        we_n  = 1'b0;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic seq_id();
        wr(12'h555, 8'hAA);
        wr(12'h2AA, 8'h55);
        wr(12'h555, 8'h90);
    endtask

    function automatic logic [15:0] exp_id(input int sel, input bit wm, input bit prot);
        logic [7:0] lo;
        logic [7:0] hi;
        lo = 8'h00;
        hi = 8'h00;
        if (sel == 0) lo = MFR;
        if (sel == 1) begin lo = DEV; hi = DHI; end
        if (sel == 2) lo = {7'd0, prot};
        return {wm ? hi : 8'h00, lo};
    endfunction

    function automatic logic [15:0] exp_arr(input bit wm);
        return wm ? array_rdata : {8'h00, array_rdata[7:0]};
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [11:0] ea [6];
        logic [7:0]  ed [6];
        int s0;
        int a0;
        ea[0] = 12'h555; ed[0] = 8'hAA;
        ea[1] = 12'h2AA; ed[1] = 8'h55;
        ea[2] = 12'h555; ed[2] = 8'h80;
        ea[3] = 12'h555; ed[3] = 8'hAA;
        ea[4] = 12'h2AA; ed[4] = 8'h55;
        ea[5] = 12'h555; ed[5] = 8'h10;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, both widths
        for (int wm = 0; wm < 2; wm++) begin
            word_mode = wm[0];
            rd(12'h000, v);
            check("R1", "reset array read", v, exp_arr(wm[0]));
        end
        check("R6", "no start at reset", start_cnt, 0);

        // R3 R4 R5 identifier sweep
        seq_id();
        for (int wm = 0; wm < 2; wm++) begin
            for (int pr = 0; pr < 2; pr++) begin
                for (int s = 0; s < 4; s++) begin
                    word_mode = wm[0];
                    sector_prot = pr[0];
                    rd(12'h000 | 12'(s), v);
                    if (s == 0)      check("R3", "mfr code", v, exp_id(s, wm[0], pr[0]));
                    else if (s == 1) check("R4", "device code", v, exp_id(s, wm[0], pr[0]));
                    else             check("R5", "protect/reserved", v, exp_id(s, wm[0], pr[0]));
                end
            end
        end
        word_mode = 1'b1;

        // R1 F0 leaves identifier mode
        wr(12'h123, 8'hF0);
        rd(12'h000, v);
        check("R1", "array after F0", v, exp_arr(1'b1));
        check("R2", "no abort when idle", abort_cnt, 0);

        // R8 stray write leaves identifier mode
        seq_id();
        rd(12'h001, v);
        check("R3", "id mode entered", v, {DHI, DEV});
        wr(12'h444, 8'h33);
        rd(12'h001, v);
        check("R8", "stray write exits id", v, exp_arr(1'b1));

        // R6 R7 full erase sequence with cycle-exact start timing
        s0 = start_cnt;
        for (int k = 0; k < 5; k++) wr(ea[k], ed[k]);
        @(negedge clk);
        addr = ea[5]; wdata = ed[5]; we_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        we_n = 1'b1;
        #1;
        check("R7", "no start before edge seen", erase_start, 1'b0);
        @(negedge clk);
        check("R7", "start one cycle after edge", erase_start, 1'b1);
        @(negedge clk);
        check("R6", "start drops after one cycle", erase_start, 1'b0);
        repeat (3) @(negedge clk);
        check("R6", "one start pulse", start_cnt - s0, 1);
        rd(12'h000, v);
        check("R6", "array mode after erase cmd", v, exp_arr(1'b1));

        // R8 corrupt each step by address and by data
        for (int bad = 0; bad < 6; bad++) begin
            for (int kind = 0; kind < 2; kind++) begin
                s0 = start_cnt;
                for (int k = 0; k < 6; k++) begin
                    if (k == bad) begin
                        if (kind == 0) wr(ea[k] ^ 12'h100, ed[k]);
                        else           wr(ea[k], ed[k] ^ 8'h01);
                    end else begin
                        wr(ea[k], ed[k]);
                    end
                end
                check("R8", "no start on corrupted step", start_cnt - s0, 0);
                rd(12'h000, v);
                check("R8", "array mode after mismatch", v, exp_arr(1'b1));
            end
        end

        // R9 busy returns status in any mode and address
        busy = 1'b1;
        status = 8'h5A;
        for (int s = 0; s < 4; s++) begin
            rd(12'h000 | 12'(s), v);
            check("R9", "status while busy", v, 16'h005A);
        end

        // R10 writes ignored while busy
        s0 = start_cnt;
        seq_id();
        for (int k = 0; k < 6; k++) wr(ea[k], ed[k]);
        check("R10", "no start while busy", start_cnt - s0, 0);
        busy = 1'b0;
        rd(12'h000, v);
        check("R10", "no mode change while busy", v, exp_arr(1'b1));
        // busy-time unlock writes must not advance: single write of 90h should not enter id
        busy = 1'b1;
        wr(12'h555, 8'hAA);
        wr(12'h2AA, 8'h55);
        busy = 1'b0;
        wr(12'h555, 8'h90);
        rd(12'h000, v);
        check("R10", "unlocks during busy not kept", v, exp_arr(1'b1));

        // R2 abort under busy / fail combinations
        for (int b = 0; b < 2; b++) begin
            for (int f = 0; f < 2; f++) begin
                a0 = abort_cnt;
                busy = b[0];
                op_fail = f[0];
                wr(12'h000, 8'hF0);
                check("R2", "abort count", abort_cnt - a0, (b | f) ? 1 : 0);
            end
        end
        busy = 1'b0;
        op_fail = 1'b0;

        // R2 R1 F0 during busy in id mode returns to array mode
        seq_id();
        busy = 1'b1;
        wr(12'h000, 8'hF0);
        busy = 1'b0;
        rd(12'h000, v);
        check("R1", "F0 while busy returns array", v, exp_arr(1'b1));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule